// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Overflow and Trap Causes

This block is the add/subtract slice of a 32-bit integer execute stage. It performs wrapping addition and subtraction, checked signed addition and subtraction that flag two's-complement overflow, and six conditional trap compares (signed and unsigned greater-or-equal and less-than, equal, not equal). It does not abort on a fault. It returns a result word together with a two-bit cause code, and the surrounding pipeline decides whether to redirect the program counter. The trap compares are not given a separate comparator. They run the shared adder in subtract mode and derive equal, signed-less-than and unsigned-less-than from its difference, carry and overflow.

An operation is presented with a four-bit operation code, two operand words `s` and `t`, and a valid strobe. The outcome shows up on the registered outputs on the next clock edge. Immediate trap forms are handled by the instantiating logic, which places a sign-extended 16-bit immediate on `t` and issues the same compare code. An operation code outside the defined set raises a separate error flag. That operation yields a zero result and no cause.

The asynchronous active-low reset is asserted at once and released through a two-stage synchronizer. The output register loads only on cycles with a valid request.

Top module: `alu_trap_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `out_valid` is 0, `result` is 0, `cause` is 00 and `op_err` is 0.
- R2: Wrapping forms return the low 32 bits of s+t (code 1) or s−t (code 3) with cause 00.
- R3: Checked add (code 0) returns the wrapped sum. When both operands share a sign bit and the sum's sign bit differs, it sets cause 01 (overflow). The other cause encodings are 00 for none and 10 for trap.
- R4: Checked subtract (code 2) returns the wrapped difference. When the operands' sign bits differ and the difference's sign bit differs from s, it sets cause 01.
- R5: Checked add and subtract whose signed result fits report cause 00.
- R6: The wrapping forms (codes 1 and 3) never report cause 01, whatever the operands.
- R7: Code 8 sets cause 10 exactly when s equals t. Code 9 sets cause 10 exactly when s differs from t.
- R8: Signed compares: code 4 sets cause 10 when s ≥ t and code 6 sets cause 10 when s < t, both as two's-complement numbers. This includes pairs whose difference overflows.
- R9: Unsigned compares: code 5 sets cause 10 when s ≥ t and code 7 sets cause 10 when s < t, both as unsigned numbers.
- R10: Every trap compare (codes 4 to 9) returns a result of 0, whether or not it traps.
- R11: Any code from 10 to 15 sets `op_err` to 1 with result 0 and cause 00. Defined codes leave `op_err` at 0.
- R12: Outputs change on the clock edge after a valid request. On a cycle without a request, `out_valid` is 0, `cause` is 00, `op_err` is 0 and `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe for this cycle |
| op | input | 4 | Operation code |
| opnd_s | input | 32 | First operand |
| opnd_t | input | 32 | Second operand or sign-extended immediate |
| out_valid | output | 1 | Registered result is from a request |
| result | output | 32 | Sum, difference, or zero for compares and errors |
| cause | output | 2 | 00 none, 01 overflow, 10 trap |
| op_err | output | 1 | Request used an undefined operation code |

## Verification
On every cycle, the assertions check the properties that hold across all operand values. These are: one cycle of latency on the valid strobe, a zero result from every compare, the absence of overflow on the wrapping forms, overflow appearing only on the checked forms, the legal cause encodings, the error flag on undefined codes, and agreement of the equal and not-equal traps with the operands. Whether a particular sum wraps to the right word and whether overflow and the ordered compares fire at the right sign boundaries can only be shown by the bench's operand pairs. Those pairs include the largest positive plus one, the most negative operand, equal operands and compares whose internal difference overflows. Holding the result across idle cycles and the reset values are also shown by directed scenarios.

// File: rtl/alu_trap_pkg.sv
package alu_trap_pkg;

  localparam int OP_W    = 4;
  localparam int CAUSE_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_TGE  = 4'd4,
    OP_TGEU = 4'd5,
    OP_TLT  = 4'd6,
    OP_TLTU = 4'd7,
    OP_TEQ  = 4'd8,
    OP_TNE  = 4'd9
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd9;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_OVF  = 2'b01,
    CAUSE_TRAP = 2'b10
  } cause_e;

  typedef enum logic [2:0] {
    COND_GE_S = 3'd0,
    COND_GE_U = 3'd1,
    COND_LT_S = 3'd2,
    COND_LT_U = 3'd3,
    COND_EQ   = 3'd4,
    COND_NE   = 3'd5
  } trap_cond_e;

  typedef struct packed {
    logic       sub;
    logic       chk_ovf;
    logic       is_trap;
    trap_cond_e cond;
    logic       bad;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_trap_rst_sync.sv
module alu_trap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/alu_trap_decode.sv
module alu_trap_decode
  import alu_trap_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output alu_ctrl_t       ctrl
);

  always_comb begin
    ctrl.sub     = 1'b1;
    ctrl.chk_ovf = 1'b0;
    ctrl.is_trap = 1'b0;
    ctrl.cond    = COND_EQ;
    ctrl.bad     = 1'b0;
    unique case (op)
      OP_ADD: begin
        ctrl.sub     = 1'b0;
        ctrl.chk_ovf = 1'b1;
      end
      OP_ADDU: begin
        ctrl.sub = 1'b0;
      end
      OP_SUB: begin
        ctrl.chk_ovf = 1'b1;
      end
      OP_SUBU: begin
        ctrl.chk_ovf = 1'b0;
      end
      OP_TGE: begin
        ctrl.is_trap = 1'b1;
        ctrl.cond    = COND_GE_S;
      end
      OP_TGEU: begin
        ctrl.is_trap = 1'b1;
        ctrl.cond    = COND_GE_U;
      end
      OP_TLT: begin
        ctrl.is_trap = 1'b1;
        ctrl.cond    = COND_LT_S;
      end
      OP_TLTU: begin
        ctrl.is_trap = 1'b1;
        ctrl.cond    = COND_LT_U;
      end
      OP_TEQ: begin
        ctrl.is_trap = 1'b1;
        ctrl.cond    = COND_EQ;
      end
      OP_TNE: begin
        ctrl.is_trap = 1'b1;
        ctrl.cond    = COND_NE;
      end
      default: begin
        ctrl.bad = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/alu_trap_addsub.sv
module alu_trap_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  always_comb begin
    b_eff     = sub ? ~b : b;
    wide      = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    sum       = wide[WIDTH-1:0];
    carry_out = wide[WIDTH];
    // Signed overflow: operands (after inversion for subtract) agree in sign
    // and the produced sign disagrees with the first operand.
    ovf       = ~(a[MSB] ^ b_eff[MSB]) & (sum[MSB] ^ a[MSB]);
  end

endmodule

// File: rtl/alu_trap_cmp.sv
module alu_trap_cmp #(
  parameter int WIDTH        = 32,
  parameter bit EQ_FROM_DIFF = 1'b1
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] diff,
  input  logic             carry_out,
  input  logic             ovf,
  output logic             eq,
  output logic             lt_s,
  output logic             lt_u
);

  localparam int MSB = WIDTH - 1;

  generate
    if (EQ_FROM_DIFF) begin : g_eq_diff
      // Zero-detect on the shared subtractor's difference.
      assign eq = (diff == '0);
    end else begin : g_eq_xor
      // Independent XOR tree, shorter than the carry chain.
      logic [WIDTH-1:0] mism;
      assign mism = a ^ b;
      assign eq   = ~|mism;
    end
  endgenerate

  always_comb begin
    lt_s = diff[MSB] ^ ovf;
    lt_u = ~carry_out;
  end

endmodule

// File: rtl/alu_trap_unit.sv
module alu_trap_unit
  import alu_trap_pkg::*;
#(
  parameter int WIDTH        = 32,
  parameter int SYNC_STAGES  = 2,
  parameter bit EQ_FROM_DIFF = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [OP_W-1:0]     op,
  input  logic [WIDTH-1:0]    opnd_s,
  input  logic [WIDTH-1:0]    opnd_t,
  output logic                out_valid,
  output logic [WIDTH-1:0]    result,
  output logic [CAUSE_W-1:0]  cause,
  output logic                op_err
);

  logic             rst_int_n;
  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] sum;
  logic             carry_out;
  logic             ovf;
  logic             eq;
  logic             lt_s;
  logic             lt_u;
  logic             trap_hit;

  logic               vld_d,   vld_q;
  logic [WIDTH-1:0]   res_d,   res_q;
  logic [CAUSE_W-1:0] cause_d, cause_q;
  logic               err_d,   err_q;
  logic               res_en;

  alu_trap_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  alu_trap_decode i_decode (
    .op   (op),
    .ctrl (ctrl)
  );

  alu_trap_addsub #(
    .WIDTH (WIDTH)
  ) i_addsub (
    .a         (opnd_s),
    .b         (opnd_t),
    .sub       (ctrl.sub),
    .sum       (sum),
    .carry_out (carry_out),
    .ovf       (ovf)
  );

  alu_trap_cmp #(
    .WIDTH        (WIDTH),
    .EQ_FROM_DIFF (EQ_FROM_DIFF)
  ) i_cmp (
    .a         (opnd_s),
    .b         (opnd_t),
    .diff      (sum),
    .carry_out (carry_out),
    .ovf       (ovf),
    .eq        (eq),
    .lt_s      (lt_s),
    .lt_u      (lt_u)
  );

  always_comb begin
    unique case (ctrl.cond)
      COND_GE_S: trap_hit = ~lt_s;
      COND_GE_U: trap_hit = ~lt_u;
      COND_LT_S: trap_hit = lt_s;
      COND_LT_U: trap_hit = lt_u;
      COND_EQ:   trap_hit = eq;
      COND_NE:   trap_hit = ~eq;
      default:   trap_hit = 1'b0;
    endcase
  end

  // Next-state logic
  always_comb begin
    res_en  = in_valid;
    vld_d   = in_valid;
    res_d   = res_q;
    cause_d = CAUSE_NONE;
    err_d   = 1'b0;
    if (in_valid) begin
      if (ctrl.bad) begin
        res_d = '0;
        err_d = 1'b1;
      end else if (ctrl.is_trap) begin
        res_d = '0;
        if (trap_hit) begin
          cause_d = CAUSE_TRAP;
        end
      end else begin
        res_d = sum;
        if (ctrl.chk_ovf && ovf) begin
          cause_d = CAUSE_OVF;
        end
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
      err_q   <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      cause_q <= cause_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign cause     = cause_q;
  assign op_err    = err_q;

endmodule

// File: rtl/alu_trap_chk.sv
module alu_trap_chk
  import alu_trap_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [OP_W-1:0]    op,
  input logic [WIDTH-1:0]   opnd_s,
  input logic [WIDTH-1:0]   opnd_t,
  input logic               out_valid,
  input logic [WIDTH-1:0]   result,
  input logic [CAUSE_W-1:0] cause,
  input logic               op_err
);

  // Counts edges since reset release; properties look back only once the
  // output registers have taken at least one post-reset load.
  logic [1:0] live_cnt;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_cnt <= 2'd0;
    end else if (live_cnt != 2'd3) begin
      live_cnt <= live_cnt + 2'd1;
    end
  end

  assign live = (live_cnt == 2'd3);

  // R12: one cycle of latency on the strobe
  assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (out_valid == $past(in_valid)));

  // R12: idle cycle reports no cause, no error and holds the result
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(in_valid)) |-> (cause == CAUSE_NONE && !op_err && result == $past(result)));

  // R3: only the three defined cause encodings appear
  assert_cause_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cause != 2'b11);

  // R6: wrapping forms never report overflow
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(in_valid) && ($past(op) == OP_ADDU || $past(op) == OP_SUBU))
      |-> (cause == CAUSE_NONE));

  // R4: overflow only follows a checked add or subtract
  assert_ovf_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cause == CAUSE_OVF) |-> ($past(in_valid) && ($past(op) == OP_ADD || $past(op) == OP_SUB)));

  // R10: compares always return zero
  assert_trap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(in_valid) && $past(op) >= OP_TGE && $past(op) <= OP_TNE)
      |-> (result == '0 && !op_err));

  // R11: undefined codes flag an error with no cause and zero result
  assert_bad_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(in_valid) && $past(op) > OP_LAST)
      |-> (op_err && cause == CAUSE_NONE && result == '0));

  // R11: error flag only after an undefined code
  assert_err_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op_err) |-> ($past(in_valid) && $past(op) > OP_LAST));

  // R7: equal / not-equal traps track operand equality
  assert_teq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(in_valid) && $past(op) == OP_TEQ)
      |-> ((cause == CAUSE_TRAP) == ($past(opnd_s) == $past(opnd_t))));

  assert_tne_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(in_valid) && $past(op) == OP_TNE)
      |-> ((cause == CAUSE_TRAP) == ($past(opnd_s) != $past(opnd_t))));

endmodule

bind alu_trap_unit alu_trap_chk #(
  .WIDTH (WIDTH)
) i_alu_trap_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .opnd_s    (opnd_s),
  .opnd_t    (opnd_t),
  .out_valid (out_valid),
  .result    (result),
  .cause     (cause),
  .op_err    (op_err)
);

// File: tb/test_alu_trap_unit.sv
`timescale 1ns/1ps
module test_alu_trap_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [31:0] opnd_s;
  logic [31:0] opnd_t;
  logic        out_valid;
  logic [31:0] result;
  logic [1:0]  cause;
  logic        op_err;

  int checks;
  int errors;
  bit done;

  alu_trap_unit i_alu_trap_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .opnd_s    (opnd_s),
    .opnd_t    (opnd_t),
    .out_valid (out_valid),
    .result    (result),
    .cause     (cause),
    .op_err    (op_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] s;
    logic [31:0] t;
    logic [31:0] r;
    logic [1:0]  c;
    logic        e;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VT [NV] = '{
    '{4'd0, 32'h8FFFFFFF, 32'h90000000, 32'h1FFFFFFF, 2'b01, 1'b0, 4'd3},  // R3
    '{4'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 2'b01, 1'b0, 4'd3},  // R3
    '{4'd0, 32'h80000000, 32'h80000000, 32'h00000000, 2'b01, 1'b0, 4'd3},  // R3
    '{4'd0, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFE, 2'b00, 1'b0, 4'd5},  // R5
    '{4'd0, 32'h00000005, 32'h00000003, 32'h00000008, 2'b00, 1'b0, 4'd5},  // R5
    '{4'd2, 32'h80000003, 32'h00000004, 32'h7FFFFFFF, 2'b01, 1'b0, 4'd4},  // R4
    '{4'd2, 32'h00000000, 32'h80000000, 32'h80000000, 2'b01, 1'b0, 4'd4},  // R4
    '{4'd2, 32'h80000000, 32'hFFFFFFFF, 32'h80000001, 2'b00, 1'b0, 4'd5},  // R5
    '{4'd1, 32'h8FFFFFFF, 32'h90000000, 32'h1FFFFFFF, 2'b00, 1'b0, 4'd6},  // R6
    '{4'd3, 32'h80000003, 32'h00000004, 32'h7FFFFFFF, 2'b00, 1'b0, 4'd6},  // R6
    '{4'd3, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 2'b00, 1'b0, 4'd2},  // R2
    '{4'd1, 32'h12340000, 32'h00005678, 32'h12345678, 2'b00, 1'b0, 4'd2},  // R2
    '{4'd8, 32'h12345678, 32'h12345678, 32'h00000000, 2'b10, 1'b0, 4'd7},  // R7
    '{4'd8, 32'h12345679, 32'h12345678, 32'h00000000, 2'b00, 1'b0, 4'd7},  // R7
    '{4'd9, 32'h12345678, 32'h12345678, 32'h00000000, 2'b00, 1'b0, 4'd7},  // R7
    '{4'd9, 32'h12345678, 32'h12345679, 32'h00000000, 2'b10, 1'b0, 4'd7},  // R7
    '{4'd4, 32'h12345679, 32'h12345678, 32'h00000000, 2'b10, 1'b0, 4'd8},  // R8
    '{4'd4, 32'h80000000, 32'h00000001, 32'h00000000, 2'b00, 1'b0, 4'd8},  // R8
    '{4'd6, 32'h80000000, 32'h00000001, 32'h00000000, 2'b10, 1'b0, 4'd8},  // R8
    '{4'd4, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 2'b10, 1'b0, 4'd8},  // R8
    '{4'd6, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 2'b00, 1'b0, 4'd8},  // R8
    '{4'd4, 32'h00000005, 32'h00000005, 32'h00000000, 2'b10, 1'b0, 4'd8},  // R8
    '{4'd6, 32'h12345678, 32'h12345679, 32'h00000000, 2'b10, 1'b0, 4'd8},  // R8
    '{4'd5, 32'h12345679, 32'h12345678, 32'h00000000, 2'b10, 1'b0, 4'd9},  // R9
    '{4'd5, 32'h80000000, 32'h00000001, 32'h00000000, 2'b10, 1'b0, 4'd9},  // R9
    '{4'd7, 32'h80000000, 32'h00000001, 32'h00000000, 2'b00, 1'b0, 4'd9},  // R9
    '{4'd7, 32'h12345678, 32'h12345679, 32'h00000000, 2'b10, 1'b0, 4'd9},  // R9
    '{4'd7, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 2'b00, 1'b0, 4'd10}, // R10
    '{4'd5, 32'h00000000, 32'h00000000, 32'h00000000, 2'b10, 1'b0, 4'd10}, // R10
    '{4'd10, 32'h11111111, 32'h22222222, 32'h00000000, 2'b00, 1'b1, 4'd11}, // R11
    '{4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 2'b00, 1'b1, 4'd11}  // R11
  };

  task automatic check(input string tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic check_outs(input string tag, input logic v, input logic [31:0] r,
                            input logic [1:0] c, input logic e);
    check(tag, "out_valid", {31'd0, out_valid}, {31'd0, v});
    check(tag, "result", result, r);
    check(tag, "cause", {30'd0, cause}, {30'd0, c});
    check(tag, "op_err", {31'd0, op_err}, {31'd0, e});
  endtask

  // Drive at the falling edge, the design loads at the rising edge,
  // sample at the following falling edge.
  task automatic issue(input logic [3:0] o, input logic [31:0] s, input logic [31:0] t);
    op       = o;
    opnd_s   = s;
    opnd_t   = t;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle_cycle();
    in_valid = 1'b0;
    op       = 4'd0;
    opnd_s   = 32'hDEADBEEF;
    opnd_t   = 32'h00000001;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks   = 0;
    errors   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    op       = 4'd0;
    opnd_s   = '0;
    opnd_t   = '0;

    // R1: reset state, while asserted and after release
    repeat (3) @(negedge clk);
    check_outs("R1", 1'b0, 32'h0, 2'b00, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outs("R1", 1'b0, 32'h0, 2'b00, 1'b0);

    // Table walk: R2..R11
    for (int i = 0; i < NV; i++) begin
      issue(VT[i].op, VT[i].s, VT[i].t);
      check_outs($sformatf("R%0d", VT[i].req), 1'b1, VT[i].r, VT[i].c, VT[i].e);
    end

    // R12: idle after an add holds the result, clears cause and error
    issue(4'd1, 32'h00000010, 32'h00000020);
    check_outs("R12", 1'b1, 32'h00000030, 2'b00, 1'b0);
    idle_cycle();
    check_outs("R12", 1'b0, 32'h00000030, 2'b00, 1'b0);

    // R12: idle after an overflow clears the cause but keeps the word
    issue(4'd0, 32'h7FFFFFFF, 32'h00000001);
    check_outs("R3", 1'b1, 32'h80000000, 2'b01, 1'b0);
    idle_cycle();
    check_outs("R12", 1'b0, 32'h80000000, 2'b00, 1'b0);

    // R12: idle after an error clears op_err
    issue(4'd12, 32'h1, 32'h2);
    check_outs("R11", 1'b1, 32'h0, 2'b00, 1'b1);
    idle_cycle();
    check_outs("R12", 1'b0, 32'h0, 2'b00, 1'b0);

    // R12: back-to-back requests, each visible one cycle later
    op = 4'd9; opnd_s = 32'h1; opnd_t = 32'h2; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    check_outs("R12", 1'b1, 32'h0, 2'b10, 1'b0);
    op = 4'd2; opnd_s = 32'h00000100; opnd_t = 32'h00000001;
    @(posedge clk); @(negedge clk);
    check_outs("R12", 1'b1, 32'h000000FF, 2'b00, 1'b0);
    in_valid = 1'b0;

    // R1: asynchronous reset mid-run clears outputs at once
    issue(4'd0, 32'h8FFFFFFF, 32'h90000000);
    #1 rst_n = 1'b0;
    #0.5;
    check_outs("R1", 1'b0, 32'h0, 2'b00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outs("R1", 1'b0, 32'h0, 2'b00, 1'b0);
    issue(4'd2, 32'h80000003, 32'h00000004);
    check_outs("R4", 1'b1, 32'h7FFFFFFF, 2'b01, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule